// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block gathers the interrupt requests of a small 16-bit processor into one 16-level pending register and reports the most urgent of them. Three groups of request pins arrive from off the core and are asynchronous: one power-down request, six user requests and two I/O-level expansion requests. A further seven internal sources, such as a timer overflow or a fault summary, arrive as pins already in the processor clock domain.

One control bit selects how the power-down and user requests are captured. In edge mode, a rising edge sets a sticky pending bit. In level mode, the pending bit tracks the synchronized input. Software writes a 16-bit enable mask and a two-bit control word through a small write port.

The block drives a valid flag and the number of the winning level. The processor pulses an acknowledge to retire the level currently shown.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, the mask is all zeros, the global enable is 0, the capture mode is level, no bit is pending, and `irq_valid` is 0.
- R2: Level 0 is the power-down request. Whenever it is pending, it is reported, whatever the mask or the global enable hold.
- R3: A mask bit of 1 enables its level and 0 disables it. A pending level with a clear mask bit is never reported, but it stays pending.
- R4: While the global enable is 0, no level other than 0 is reported.
- R5: When several eligible levels are pending, the lowest level number is reported.
- R6: In edge mode (control bit 1 = 1), a rising edge on the power-down input or on a user input sets its pending bit. The bit stays set after the input falls and is cleared only by acknowledge. An input held high does not set the bit again.
- R7: In level mode (control bit 1 = 0), the pending bits of the power-down and user inputs follow the synchronized inputs. Acknowledge has no effect on them while an input stays high.
- R8: The two I/O-level inputs map to levels 7 and 8 and are always level-captured, active high.
- R9: The internal inputs map to levels 9 to 15. Each sets its pending bit in any cycle in which it is high, and the bit stays set until it is acknowledged.
- R10: Acknowledge while `irq_valid` is 1 clears the pending bit of the reported level at that clock edge. A new request arriving on the same edge takes precedence over the clear.
- R11: The user inputs map to levels 1 to 6. A change on any asynchronous input reaches the outputs after three rising clock edges.
- R12: A write with `cfg_sel` = 0 loads the mask from `cfg_wdata`. A write with `cfg_sel` = 1 loads the global enable from bit 0 and the edge-mode flag from bit 1. Either write takes effect on the outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_req | input | 1 | Asynchronous power-down request (level 0) |
| usr_req | input | 6 | Asynchronous user requests 0..5 (levels 1..6) |
| iol_req | input | 2 | Asynchronous I/O-level requests (levels 7, 8) |
| int_req | input | 7 | Synchronous internal requests (levels 9..15) |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the mask, 1 selects the control word |
| cfg_wdata | input | 16 | Write data |
| ack | input | 1 | Acknowledge of the reported level |
| irq_valid | output | 1 | An eligible level is pending |
| irq_level | output | 4 | Number of the winning level |

## Verification
Several properties are checked on every cycle:
- the power-down bit always wins whenever it is pending;
- no masked level and, with the global enable off, no level above 0 is ever reported;
- no lower eligible level hides behind the one reported;
- an acknowledged internal level is gone on the next cycle;
- an edge-captured bit holds until it is acknowledged.

Other behaviours only the bench scenarios can show:
- the three-edge latency through the synchronizers;
- the difference between edge and level capture for one input waveform;
- an input held high not re-arming in edge mode;
- the effect of each register write on the outputs.

// File: rtl/irq_pkg.sv
package irq_pkg;

    parameter int IRQ_LEVELS  = 16;
    parameter int USR_COUNT   = 6;
    parameter int IOL_COUNT   = 2;
    parameter int SYNC_DEPTH  = 2;

    typedef enum logic {
        SEL_MASK = 1'b0,
        SEL_CTRL = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic edge_mode;
        logic gie;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [1:0] w);
        ctrl_t c;
        c.edge_mode = w[1];
        c.gie       = w[0];
        return c;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 9,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= async_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int LEVELS = 16,
    parameter int EXT_N  = 7,
    parameter int IOL_N  = 2,
    localparam int INT_N = LEVELS - EXT_N - IOL_N,
    localparam int SYN_N = EXT_N + IOL_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_mode,
    input  logic [SYN_N-1:0]  sync_i,
    input  logic [INT_N-1:0]  int_i,
    input  logic [LEVELS-1:0] clr_i,
    output logic [LEVELS-1:0] pend_o
);
    logic [EXT_N-1:0] prev_q;

    // power-down and user requests: selectable capture
    for (genvar i = 0; i < EXT_N; i++) begin : g_ext
        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q[i] <= 1'b0;
                pend_o[i] <= 1'b0;
            end else begin
                prev_q[i] <= sync_i[i];
                if (edge_mode)
                    pend_o[i] <= (sync_i[i] & ~prev_q[i]) | (pend_o[i] & ~clr_i[i]);
                else
                    pend_o[i] <= sync_i[i];
            end
        end
    end

    // I/O-level requests: always level captured
    for (genvar i = EXT_N; i < SYN_N; i++) begin : g_iol
        always_ff @(posedge clk) begin
            if (rst) pend_o[i] <= 1'b0;
            else     pend_o[i] <= sync_i[i];
        end
    end

    // internal requests: sticky until acknowledged
    for (genvar k = 0; k < INT_N; k++) begin : g_int
        always_ff @(posedge clk) begin
            if (rst) pend_o[SYN_N+k] <= 1'b0;
            else     pend_o[SYN_N+k] <= int_i[k] | (pend_o[SYN_N+k] & ~clr_i[SYN_N+k]);
        end
    end

    logic unused_clr;
    assign unused_clr = ^clr_i[SYN_N-1:EXT_N];
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N = 16,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         valid_o,
    output logic [W-1:0] level_o
);
    always_comb begin
        valid_o = |req_i;
        level_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) level_o = W'(i);
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int N_LVL  = IRQ_LEVELS,
    parameter int N_USR  = USR_COUNT,
    parameter int N_IOL  = IOL_COUNT,
    parameter int N_SYNC = SYNC_DEPTH,
    localparam int EXT_N = 1 + N_USR,
    localparam int SYN_N = EXT_N + N_IOL,
    localparam int INT_N = N_LVL - SYN_N,
    localparam int LVL_W = $clog2(N_LVL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic [N_USR-1:0] usr_req,
    input  logic [N_IOL-1:0] iol_req,
    input  logic [INT_N-1:0] int_req,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [N_LVL-1:0] cfg_wdata,
    input  logic             ack,
    output logic             irq_valid,
    output logic [LVL_W-1:0] irq_level
);
    logic [N_LVL-1:0] mask_q;
    ctrl_t            ctrl_q;
    logic [SYN_N-1:0] sync_req;
    logic [N_LVL-1:0] pend;
    logic [N_LVL-1:0] elig;
    logic [N_LVL-1:0] clr_vec;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            ctrl_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == SEL_MASK) mask_q <= cfg_wdata;
            else                                 ctrl_q <= ctrl_from_word(cfg_wdata[1:0]);
        end
    end

    irq_sync #(.WIDTH(SYN_N), .STAGES(N_SYNC)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i({iol_req, usr_req, pwr_req}),
        .sync_o (sync_req)
    );

    irq_pending #(.LEVELS(N_LVL), .EXT_N(EXT_N), .IOL_N(N_IOL)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .edge_mode(ctrl_q.edge_mode),
        .sync_i   (sync_req),
        .int_i    (int_req),
        .clr_i    (clr_vec),
        .pend_o   (pend)
    );

    always_comb begin
        elig    = pend & (ctrl_q.gie ? mask_q : '0);
        elig[0] = pend[0];
    end

    irq_prio #(.N(N_LVL)) u_prio (
        .req_i  (elig),
        .valid_o(irq_valid),
        .level_o(irq_level)
    );

    always_comb begin
        clr_vec = '0;
        if (ack && irq_valid) clr_vec[irq_level] = 1'b1;
    end
endmodule

// File: rtl/irq_ctrl_checker.sv
module irq_ctrl_checker #(
    parameter int N_LVL    = 16,
    parameter int INT_BASE = 9,
    localparam int INT_N   = N_LVL - INT_BASE,
    localparam int LVL_W   = $clog2(N_LVL)
) (
    input logic             clk,
    input logic             rst,
    input logic             ack,
    input logic [INT_N-1:0] int_req,
    input logic             irq_valid,
    input logic [LVL_W-1:0] irq_level,
    input logic [N_LVL-1:0] pend,
    input logic [N_LVL-1:0] mask_q,
    input logic             gie,
    input logic             edge_mode
);
    logic [N_LVL-1:0] ok_lvl;
    logic             lower_hit;
    logic             int_hit;

    always_comb begin
        ok_lvl    = gie ? (pend & mask_q) : '0;
        ok_lvl[0] = pend[0];
        lower_hit = 1'b0;
        for (int j = 0; j < N_LVL; j++)
            if (j < int'(irq_level) && ok_lvl[j]) lower_hit = 1'b1;
        int_hit = 1'b0;
        for (int k = 0; k < INT_N; k++)
            if (int'(irq_level) == INT_BASE + k && int_req[k]) int_hit = 1'b1;
    end

    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq_valid);

    p_pwr_wins_r2: assert property (@(posedge clk) disable iff (rst)
        pend[0] |-> (irq_valid && irq_level == '0));

    p_masked_silent_r3: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_level != '0) |-> mask_q[irq_level]);

    p_gie_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && irq_level != '0) |-> gie);

    p_lowest_first_r5: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> !lower_hit);

    p_edge_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && pend[1] && !(ack && irq_valid && irq_level == LVL_W'(1))) |=> pend[1]);

    p_ack_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_valid && int'(irq_level) >= INT_BASE && !int_hit) |=> !pend[$past(irq_level)]);
endmodule

bind irq_ctrl irq_ctrl_checker #(.N_LVL(N_LVL), .INT_BASE(SYN_N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .int_req  (int_req),
    .irq_valid(irq_valid),
    .irq_level(irq_level),
    .pend     (pend),
    .mask_q   (mask_q),
    .gie      (ctrl_q.gie),
    .edge_mode(ctrl_q.edge_mode)
);

// File: tb/irq_ctrl_tb_top.sv
module irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_req = 1'b0;
    logic [5:0]  usr_req = '0;
    logic [1:0]  iol_req = '0;
    logic [6:0]  int_req = '0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        ack = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    irq_ctrl dut_i (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .usr_req(usr_req),
        .iol_req(iol_req), .int_req(int_req), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ack(ack),
        .irq_valid(irq_valid), .irq_level(irq_level)
    );

    // {mask[15:0], ctrl{edge,gie}, usr[5:0], iol[1:0], pwr, exp_valid, exp_level[3:0]}
    localparam int NV = 9;
    localparam logic [31:0] VECS [NV] = '{
        {16'h0000, 2'b01, 6'b000000, 2'b00, 1'b0, 1'b0, 4'd0},  // R1 nothing pending
        {16'h0000, 2'b00, 6'b000000, 2'b00, 1'b1, 1'b1, 4'd0},  // R2 power-down ignores mask/gie
        {16'hFFFF, 2'b00, 6'b000100, 2'b00, 1'b0, 1'b0, 4'd0},  // R4 gie off
        {16'hFFFF, 2'b01, 6'b000100, 2'b00, 1'b0, 1'b1, 4'd3},  // R7 usr2 -> level 3
        {16'hFFFF, 2'b01, 6'b100100, 2'b01, 1'b0, 1'b1, 4'd3},  // R5 lowest wins
        {16'hFFF7, 2'b01, 6'b100100, 2'b01, 1'b0, 1'b1, 4'd6},  // R3 level 3 masked
        {16'h0180, 2'b01, 6'b111111, 2'b10, 1'b0, 1'b1, 4'd8},  // R8 only iol levels enabled
        {16'hFFFF, 2'b01, 6'b000000, 2'b11, 1'b0, 1'b1, 4'd7},  // R8 iol0 -> level 7
        {16'hFFFF, 2'b01, 6'b000001, 2'b00, 1'b1, 1'b1, 4'd0}   // R5 power-down above usr0
    };

    task automatic check(input string req, input logic v_exp, input logic [3:0] l_exp);
        checks++;
        if (irq_valid !== v_exp || (v_exp && irq_level !== l_exp)) begin
            errors++;
            $display("FAIL %s: valid=%0b level=%0d expected valid=%0b level=%0d",
                     req, irq_valid, irq_level, v_exp, l_exp);
        end
    endtask

    task automatic write_cfg(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pulse();
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        pwr_req = 1'b1;                                   // ignored during reset
        wait_n(4);
        check("R1 during reset", 1'b0, 4'd0);
        pwr_req = 1'b0;
        rst = 1'b0;
        wait_n(4);
        check("R1 after reset", 1'b0, 4'd0);

        // table walk, level mode
        for (int v = 0; v < NV; v++) begin
            logic [31:0] e;
            e = VECS[v];
            usr_req = e[13:8];
            iol_req = e[7:6];
            pwr_req = e[5];
            write_cfg(1'b0, e[31:16]);
            write_cfg(1'b1, {14'd0, e[15:14]});
            wait_n(4);
            check($sformatf("R3/R4/R5/R7/R8 vector %0d", v), e[4], e[3:0]);
        end
        usr_req = '0; iol_req = '0; pwr_req = 1'b0;
        write_cfg(1'b0, 16'hFFFF);
        write_cfg(1'b1, 16'h0001);
        wait_n(4);
        check("R7 all inputs low", 1'b0, 4'd0);

        // R11 latency: visible after the third rising edge
        @(negedge clk); usr_req[0] = 1'b1;
        wait_n(2);
        check("R11 not yet after two edges", 1'b0, 4'd0);
        wait_n(1);
        check("R11 visible after three edges", 1'b1, 4'd1);

        // R7 acknowledge has no effect while level input is high
        ack_pulse();
        check("R7 ack ignored while high", 1'b1, 4'd1);
        usr_req[0] = 1'b0;
        wait_n(4);
        check("R7 follows input low", 1'b0, 4'd0);

        // R6 edge mode: pulse is held
        write_cfg(1'b1, 16'h0003);
        @(negedge clk); usr_req[1] = 1'b1;
        wait_n(2); usr_req[1] = 1'b0;
        wait_n(5);
        check("R6 edge held after input falls", 1'b1, 4'd2);
        ack_pulse();
        check("R10 ack clears edge bit", 1'b0, 4'd0);

        // R6 held-high input does not re-arm
        @(negedge clk); usr_req[2] = 1'b1;
        wait_n(5);
        check("R6 rising edge sets level 3", 1'b1, 4'd3);
        ack_pulse();
        wait_n(2);
        check("R6 no re-arm while held high", 1'b0, 4'd0);
        usr_req[2] = 1'b0;
        wait_n(4);

        // R9 internal sticky requests, R10 ack moves to next
        @(negedge clk); int_req = 7'b1000001;
        @(negedge clk); int_req = '0;
        check("R9 internal level 9 wins", 1'b1, 4'd9);
        wait_n(3);
        check("R9 internal stays pending", 1'b1, 4'd9);
        ack_pulse();
        check("R10 next level 15 after ack", 1'b1, 4'd15);
        ack_pulse();
        check("R10 all cleared", 1'b0, 4'd0);

        // R4 / R12 / R3 register writes
        write_cfg(1'b1, 16'h0002);
        @(negedge clk); int_req[2] = 1'b1;
        @(negedge clk); int_req[2] = 1'b0;
        check("R4 gie off hides level 11", 1'b0, 4'd0);
        write_cfg(1'b1, 16'h0003);
        check("R12 gie write reveals level 11", 1'b1, 4'd11);
        write_cfg(1'b0, 16'h0000);
        check("R3 mask clear hides level 11", 1'b0, 4'd0);
        write_cfg(1'b0, 16'hFFFF);
        check("R3 masked bit stayed pending", 1'b1, 4'd11);
        ack_pulse();
        check("R10 level 11 cleared", 1'b0, 4'd0);

        // R2 power-down in edge mode with mask and gie off
        write_cfg(1'b1, 16'h0002);
        write_cfg(1'b0, 16'h0000);
        @(negedge clk); pwr_req = 1'b1;
        wait_n(2); pwr_req = 1'b0;
        wait_n(5);
        check("R2 power-down edge with mask/gie off", 1'b1, 4'd0);
        ack_pulse();
        check("R10 power-down acknowledged", 1'b0, 4'd0);

        done = 1;
        finish_run();
    end
endmodule